// File: doc/BRIEF.md
# Programmable CRC32 Stream Checker

The block computes a 32-bit cyclic redundancy signature over a block of 32-bit words. Words arrive on a valid/ready stream. A small register-style write port sets up each block before it starts: the generator polynomial, the starting value, the expected signature, the word count, a constant word, the operating mode and two input reordering options. A write to the start address launches the block. The block accepts exactly the programmed number of words. Then it raises a one-cycle completion pulse with the signature, a comparison flag, and a fault pulse if the signature differs from the expected one.

There are four modes. Scan mode hashes the incoming words and drops them. Pass-through mode hashes each word and also hands it to an output stream. The output's backpressure stalls the input, so no word is hashed twice. Check mode hashes the incoming words and compares each one with the constant word. The index of the first word that differs is held, together with a sticky error flag, until software clears it. Generate mode ignores the input and produces the constant word the programmed number of times on the output stream. It hashes each word it produces.

Top module: `crc_word_checker`

## Requirements
- R1: After reset, `done`, `fault`, `busy`, `in_ready`, `out_valid` and `verr_flag` are all low.
- R2: Any write to address 6 loads the seed (address 1) into the signature register and starts a block. With a word count of zero, `done` pulses in the next cycle and `sig_out` equals the seed.
- R3: Each accepted word updates the signature MSB-first, one bit per step over 32 steps. A step XORs the polynomial (address 0) into the state when the state's top bit differs from the data bit. There is no final inversion.
- R4: Control register (address 3) bit 3 swaps the byte order of each hashed word. Bit 2 then reverses all 32 bits. The bytes are swapped first, then the bits are reversed.
- R5: In pass-through mode (control bits [1:0] = 1), `out_data` equals `in_data` and `out_valid` follows `in_valid`. `in_ready` is low whenever `out_ready` is low. Each handshaked word is hashed exactly once.
- R6: In scan mode (control bits [1:0] = 0), `out_valid` stays low and `in_ready` is high while a block runs.
- R7: In generate mode (control bits [1:0] = 3), `in_ready` stays low. `out_valid` is high while the block runs, and `out_data` carries the constant word (address 5) for exactly the programmed count of output handshakes.
- R8: In check mode (control bits [1:0] = 2), the first accepted word that differs from the constant word sets `verr_flag` and stores its zero-based index in `verr_index`. Later mismatches leave the index unchanged. Writing 1 to bit 0 at address 7 clears both.
- R9: `done` is a one-cycle pulse in the cycle after the edge that accepts the last word. `busy` and `in_ready` are low in that cycle.
- R10: With `done`, `match` shows whether the signature equals the expected value (address 2). `fault` pulses only together with `done`, and only when the two differ.
- R11: The word count (address 4) is an unsigned `LEN_W`-bit value. The block accepts exactly that many words before `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 32 | Input word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 32 | Output word |
| busy | output | 1 | Block in progress |
| done | output | 1 | One-cycle end-of-block pulse |
| sig_out | output | 32 | Current signature |
| match | output | 1 | Signature equals expected value |
| fault | output | 1 | One-cycle mismatch pulse |
| verr_flag | output | 1 | Sticky check-mode mismatch flag |
| verr_index | output | LEN_W | Index of the first mismatching word |

## Verification
The bench builds the block with `LEN_W` = 8. This keeps every block short and makes a zero-length block cheap to reach.

Blocks of one to six words exercise these cases:
- two different polynomials;
- all three mirroring settings;
- a seed-only block with a count of zero;
- a check block with mismatches at indices 1 and 3, which shows that the first index is held.

A throttled `out_ready` pattern in pass-through mode shows the stall, and the signature shows that no word was hashed twice.

// File: rtl/crc_chk_pkg.sv
package crc_chk_pkg;

  localparam int unsigned CRC_W = 32;

  typedef enum logic [1:0] {
    MODE_SCAN   = 2'd0,
    MODE_XFER   = 2'd1,
    MODE_VERIFY = 2'd2,
    MODE_FILL   = 2'd3
  } crc_mode_e;

  typedef struct packed {
    logic      byte_swap;
    logic      bit_rev;
    crc_mode_e mode;
  } crc_ctrl_t;

  // one word folded into the state, most significant data bit first
  function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] state,
                                               input logic [CRC_W-1:0] word,
                                               input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] s;
    s = state;
    for (int i = CRC_W - 1; i >= 0; i--) begin
      if (s[CRC_W-1] ^ word[i]) s = (s << 1) ^ poly;
      else                      s = s << 1;
    end
    return s;
  endfunction

  function automatic logic [CRC_W-1:0] word_reorder(input logic [CRC_W-1:0] w,
                                                    input logic bit_rev,
                                                    input logic byte_swap);
    logic [CRC_W-1:0] t;
    logic [CRC_W-1:0] r;
    t = byte_swap ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
    for (int i = 0; i < CRC_W; i++) r[i] = t[CRC_W-1-i];
    return bit_rev ? r : t;
  endfunction

endpackage

// File: rtl/crc_cfg_regs.sv
module crc_cfg_regs
  import crc_chk_pkg::*;
#(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CRC_W-1:0]  wdata,
  output logic [CRC_W-1:0]  poly,
  output logic [CRC_W-1:0]  seed,
  output logic [CRC_W-1:0]  expect_sig,
  output crc_ctrl_t         ctrl,
  output logic [LEN_W-1:0]  len,
  output logic [CRC_W-1:0]  fill_word,
  output logic              start_pulse,
  output logic              clear_pulse
);

  localparam logic [ADDR_W-1:0] A_POLY   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SEED   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_EXPECT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_LEN    = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_FILL   = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_START  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(7);

  assign start_pulse = we && (addr == A_START);
  assign clear_pulse = we && (addr == A_CLEAR) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poly       <= 32'h04C1_1DB7;
      seed       <= '1;
      expect_sig <= '0;
      ctrl       <= '0;
      len        <= '0;
      fill_word  <= '0;
    end else if (we) begin
      case (addr)
        A_POLY:   poly       <= wdata;
        A_SEED:   seed       <= wdata;
        A_EXPECT: expect_sig <= wdata;
        A_CTRL:   ctrl       <= crc_ctrl_t'(wdata[3:0]);
        A_LEN:    len        <= wdata[LEN_W-1:0];
        A_FILL:   fill_word  <= wdata;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/crc_stream_route.sv
module crc_stream_route
  import crc_chk_pkg::*;
(
  input  crc_mode_e        mode,
  input  logic             busy,
  input  logic             in_valid,
  input  logic [CRC_W-1:0] in_data,
  input  logic             out_ready,
  input  logic [CRC_W-1:0] fill_word,
  output logic             in_ready,
  output logic             out_valid,
  output logic [CRC_W-1:0] out_data,
  output logic             beat,
  output logic [CRC_W-1:0] beat_word
);

  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = in_data;
    beat_word = in_data;
    case (mode)
      MODE_SCAN, MODE_VERIFY: in_ready = busy;
      MODE_XFER: begin
        in_ready  = busy && out_ready;
        out_valid = busy && in_valid;
      end
      MODE_FILL: begin
        out_valid = busy;
        out_data  = fill_word;
        beat_word = fill_word;
      end
      default: ;
    endcase
    beat = (mode == MODE_FILL) ? (out_valid && out_ready) : (in_valid && in_ready);
  end

endmodule

// File: rtl/crc_sig_engine.sv
module crc_sig_engine
  import crc_chk_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CRC_W-1:0] seed,
  input  logic [CRC_W-1:0] poly,
  input  logic [CRC_W-1:0] expect_sig,
  input  logic [LEN_W-1:0] len,
  input  logic             bit_rev,
  input  logic             byte_swap,
  input  logic             beat,
  input  logic [CRC_W-1:0] beat_word,
  output logic             busy,
  output logic             done,
  output logic             match,
  output logic             fault,
  output logic [CRC_W-1:0] sig,
  output logic [LEN_W-1:0] index
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [CRC_W-1:0] sig_nxt;
  logic             last_beat;

  assign sig_nxt   = crc_fold(sig, word_reorder(beat_word, bit_rev, byte_swap), poly);
  assign last_beat = beat && (index == len - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig   <= '0;
      index <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
      match <= 1'b0;
      fault <= 1'b0;
    end else if (start) begin
      sig   <= seed;
      index <= '0;
      busy  <= (len != '0);
      done  <= (len == '0);
      match <= (seed == expect_sig);
      fault <= (len == '0) && (seed != expect_sig);
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      if (beat && busy) begin
        sig   <= sig_nxt;
        index <= index + ONE;
        if (last_beat) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          match <= (sig_nxt == expect_sig);
          fault <= (sig_nxt != expect_sig);
        end
      end
    end
  end

  a_r10_fault_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done && !match);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done);
  a_r9_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r11_index_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> index < len);

endmodule

// File: rtl/crc_verify_trap.sv
module crc_verify_trap
  import crc_chk_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             check_en,
  input  logic             beat,
  input  logic [CRC_W-1:0] word,
  input  logic [CRC_W-1:0] ref_word,
  input  logic [LEN_W-1:0] beat_index,
  input  logic             clear,
  output logic             flag,
  output logic [LEN_W-1:0] first_index
);

  logic miss;
  assign miss = check_en && beat && (word != ref_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag        <= 1'b0;
      first_index <= '0;
    end else if (miss) begin
      flag <= 1'b1;
      if (!flag) first_index <= beat_index;
    end else if (clear) begin
      flag        <= 1'b0;
      first_index <= '0;
    end
  end

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clear |=> flag);
  a_r8_index_held: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clear |=> $stable(first_index));

endmodule

// File: rtl/crc_word_checker.sv
module crc_word_checker
  import crc_chk_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_data,
  output logic             busy,
  output logic             done,
  output logic [31:0]      sig_out,
  output logic             match,
  output logic             fault,
  output logic             verr_flag,
  output logic [LEN_W-1:0] verr_index
);

  logic [CRC_W-1:0] poly, seed, expect_sig, fill_word, beat_word;
  crc_ctrl_t        ctrl;
  logic [LEN_W-1:0] len, beat_index;
  logic             start_pulse, clear_pulse, beat;

  crc_cfg_regs #(.LEN_W(LEN_W), .ADDR_W(3)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .poly(poly), .seed(seed), .expect_sig(expect_sig), .ctrl(ctrl), .len(len),
    .fill_word(fill_word), .start_pulse(start_pulse), .clear_pulse(clear_pulse)
  );

  crc_stream_route route_i (
    .mode(ctrl.mode), .busy(busy), .in_valid(in_valid), .in_data(in_data),
    .out_ready(out_ready), .fill_word(fill_word), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .beat(beat), .beat_word(beat_word)
  );

  crc_sig_engine #(.LEN_W(LEN_W)) engine_i (
    .clk(clk), .rst_n(rst_n), .start(start_pulse), .seed(seed), .poly(poly),
    .expect_sig(expect_sig), .len(len), .bit_rev(ctrl.bit_rev),
    .byte_swap(ctrl.byte_swap), .beat(beat), .beat_word(beat_word), .busy(busy),
    .done(done), .match(match), .fault(fault), .sig(sig_out), .index(beat_index)
  );

  crc_verify_trap #(.LEN_W(LEN_W)) trap_i (
    .clk(clk), .rst_n(rst_n), .check_en(ctrl.mode == MODE_VERIFY), .beat(beat),
    .word(in_data), .ref_word(fill_word), .beat_index(beat_index),
    .clear(clear_pulse), .flag(verr_flag), .first_index(verr_index)
  );

  a_r6_scan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.mode == MODE_SCAN |-> !out_valid);
  a_r5_stall_input: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.mode == MODE_XFER && !out_ready |-> !in_ready);
  a_r7_fill_no_input: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.mode == MODE_FILL |-> !in_ready);
  a_r9_ready_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy);

endmodule

// File: tb/crc_word_checker_tb_top.sv
module crc_word_checker_tb_top;

  localparam int LW = 8;

  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic        in_valid = 0, out_ready = 1;
  logic [31:0] in_data = 0;
  logic        in_ready, out_valid, busy, done, match, fault, verr_flag;
  logic [31:0] out_data, sig_out;
  logic [LW-1:0] verr_index;

  int n_checks = 0, n_fail = 0;
  logic [31:0] stim [0:15];
  logic [31:0] exp_out [$];
  logic [32:0] exp_done [$];
  logic [1:0]  cur_mode = 0;
  bit          throttle = 0;
  bit          finished = 0;
  int          cyc = 0;

  always #2 clk = ~clk;

  crc_word_checker #(.LEN_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .busy(busy), .done(done), .sig_out(sig_out),
    .match(match), .fault(fault), .verr_flag(verr_flag), .verr_index(verr_index)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference signature, bit stream taken from the top of the word down
  function automatic logic [31:0] ref_step(input logic [31:0] c, input logic [31:0] w, input logic [31:0] p);
    for (int j = 0; j < 32; j++) begin
      logic top;
      top = c[31];
      c = {c[30:0], 1'b0};
      if (top != w[31-j]) c = c ^ p;
    end
    return c;
  endfunction

  function automatic logic [31:0] ref_prep(input logic [31:0] w, input bit brev, input bit bswap);
    logic [31:0] t, r;
    t = w;
    if (bswap) for (int b = 0; b < 4; b++) t[8*b +: 8] = w[8*(3-b) +: 8];
    for (int j = 0; j < 32; j++) r[31-j] = t[j];
    return brev ? r : t;
  endfunction

  function automatic logic [31:0] ref_block(input logic [31:0] seed, input logic [31:0] p,
                                            input int n, input bit brev, input bit bswap);
    logic [31:0] c;
    c = seed;
    for (int k = 0; k < n; k++) c = ref_step(c, ref_prep(stim[k], brev, bswap), p);
    return c;
  endfunction

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic setup(input logic [31:0] p, input logic [31:0] s, input logic [31:0] e,
                       input logic [3:0] ctl, input int n, input logic [31:0] k);
    cfg_write(3'd0, p);
    cfg_write(3'd1, s);
    cfg_write(3'd2, e);
    cfg_write(3'd3, {28'd0, ctl});
    cfg_write(3'd4, n);
    cfg_write(3'd5, k);
    cur_mode = ctl[1:0];
  endtask

  task automatic drive_words(input int n);
    int k = 0;
    bit acc;
    if (n == 0) return;
    in_valid = 1; in_data = stim[0];
    while (k < n) begin
      @(negedge clk); acc = in_valid && in_ready;
      @(posedge clk); #1;
      if (acc) begin
        k++;
        if (k < n) in_data = stim[k]; else in_valid = 0;
      end
    end
  endtask

  task automatic settle(); repeat (4) @(posedge clk); #1; endtask

  // monitor: output stream, completion and stall checks
  always @(negedge clk) if (rst_n && !finished) begin
    cyc++;
    if (out_valid && out_ready) begin
      if (exp_out.size() == 0) check(0, "R5/R7 unexpected output word", out_data, 0);
      else begin
        logic [31:0] e;
        e = exp_out.pop_front();
        check(out_data == e, "R5/R7 output word", out_data, e);
      end
    end
    if (cur_mode == 2'd0 && out_valid) check(0, "R6 scan output", out_valid, 0);
    if (cur_mode == 2'd3 && in_ready) check(0, "R7 fill input ready", in_ready, 0);
    if (cur_mode == 2'd1 && !out_ready && in_ready) check(0, "R5 stall", in_ready, 0);
    if (fault && !done) check(0, "R10 fault without done", fault, 0);
    if (done) begin
      if (exp_done.size() == 0) check(0, "R9 unexpected done", done, 0);
      else begin
        logic [32:0] e;
        e = exp_done.pop_front();
        check(sig_out == e[31:0], "R3 signature at done", sig_out, e[31:0]);
        check(match == e[32], "R10 match", match, e[32]);
        check(fault == !e[32], "R10 fault", fault, !e[32]);
        check(!busy && !in_ready, "R9 idle at done", {busy, in_ready}, 0);
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (throttle) out_ready = (cyc % 3) != 0;
  end

  task automatic report();
    finished = 1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    logic [31:0] s;
    #1;
    check(!done && !fault && !busy && !in_ready && !out_valid && !verr_flag,
          "R1 reset outputs", {done, fault, busy, in_ready, out_valid, verr_flag}, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    check(!done && !busy && !in_ready && !out_valid, "R1 after reset release",
          {done, busy, in_ready, out_valid}, 0);

    // R3 R6 R9 R10 R11: scan, four words, correct expected value
    stim[0] = 32'h1234_5678; stim[1] = 32'hDEAD_BEEF; stim[2] = 32'h0; stim[3] = 32'hFFFF_FFFF;
    s = ref_block(32'hFFFF_FFFF, 32'h04C1_1DB7, 4, 0, 0);
    setup(32'h04C1_1DB7, 32'hFFFF_FFFF, s, 4'b0000, 4, 0);
    exp_done.push_back({1'b1, s});
    cfg_write(3'd6, 0);
    drive_words(4);
    settle();

    // R10: same words, wrong expected value, another polynomial
    s = ref_block(32'h0, 32'h1EDC_6F41, 4, 0, 0);
    setup(32'h1EDC_6F41, 32'h0, s ^ 32'h1, 4'b0000, 4, 0);
    exp_done.push_back({1'b0, s});
    cfg_write(3'd6, 0);
    drive_words(4);
    settle();

    // R2: zero-length block reports the seed
    setup(32'h04C1_1DB7, 32'hA5A5_0F0F, 32'hA5A5_0F0F, 4'b0000, 0, 0);
    exp_done.push_back({1'b1, 32'hA5A5_0F0F});
    cfg_write(3'd6, 0);
    settle();

    // R4: both mirroring options, then byte swap alone, then bit reversal alone
    stim[0] = 32'h0102_0304; stim[1] = 32'h8000_0001; stim[2] = 32'hC3A5_5A3C;
    s = ref_block(32'hFFFF_FFFF, 32'h04C1_1DB7, 3, 1, 1);
    setup(32'h04C1_1DB7, 32'hFFFF_FFFF, s, 4'b1100, 3, 0);
    exp_done.push_back({1'b1, s});
    cfg_write(3'd6, 0); drive_words(3); settle();
    s = ref_block(32'hFFFF_FFFF, 32'h04C1_1DB7, 3, 0, 1);
    setup(32'h04C1_1DB7, 32'hFFFF_FFFF, s, 4'b1000, 3, 0);
    exp_done.push_back({1'b1, s});
    cfg_write(3'd6, 0); drive_words(3); settle();
    s = ref_block(32'hFFFF_FFFF, 32'h04C1_1DB7, 3, 1, 0);
    setup(32'h04C1_1DB7, 32'hFFFF_FFFF, s, 4'b0100, 3, 0);
    exp_done.push_back({1'b1, s});
    cfg_write(3'd6, 0); drive_words(3); settle();

    // R5: pass-through with throttled output, each word hashed once
    for (int k = 0; k < 6; k++) stim[k] = 32'h1111_0000 * (k + 1) + k;
    s = ref_block(32'hFFFF_FFFF, 32'h04C1_1DB7, 6, 0, 0);
    setup(32'h04C1_1DB7, 32'hFFFF_FFFF, s, 4'b0001, 6, 0);
    for (int k = 0; k < 6; k++) exp_out.push_back(stim[k]);
    exp_done.push_back({1'b1, s});
    throttle = 1;
    cfg_write(3'd6, 0);
    drive_words(6);
    settle();
    throttle = 0; out_ready = 1;
    @(posedge clk); #1;
    check(exp_out.size() == 0, "R5 all words forwarded", exp_out.size(), 0);

    // R7: generate mode, three constant words
    for (int k = 0; k < 3; k++) stim[k] = 32'h5EED_C0DE;
    s = ref_block(32'h0, 32'h04C1_1DB7, 3, 0, 0);
    setup(32'h04C1_1DB7, 32'h0, s, 4'b0011, 3, 32'h5EED_C0DE);
    for (int k = 0; k < 3; k++) exp_out.push_back(32'h5EED_C0DE);
    exp_done.push_back({1'b1, s});
    in_valid = 1; in_data = 32'hBAD0_BAD0;
    cfg_write(3'd6, 0);
    repeat (8) @(posedge clk); #1;
    in_valid = 0;
    check(exp_out.size() == 0, "R7 fill count", exp_out.size(), 0);
    settle();

    // R8: check mode, mismatches at indices 1 and 3
    stim[0] = 32'h7777_7777; stim[1] = 32'h7777_7776; stim[2] = 32'h7777_7777;
    stim[3] = 32'h0; stim[4] = 32'h7777_7777;
    s = ref_block(32'hFFFF_FFFF, 32'h04C1_1DB7, 5, 0, 0);
    setup(32'h04C1_1DB7, 32'hFFFF_FFFF, s, 4'b0010, 5, 32'h7777_7777);
    exp_done.push_back({1'b1, s});
    cfg_write(3'd6, 0);
    drive_words(5);
    settle();
    @(negedge clk);
    check(verr_flag == 1'b1, "R8 sticky flag", verr_flag, 1);
    check(verr_index == LW'(1), "R8 first index", verr_index, 1);
    @(posedge clk); #1;
    cfg_write(3'd7, 32'h0);
    @(negedge clk);
    check(verr_flag == 1'b1, "R8 clear needs bit0", verr_flag, 1);
    @(posedge clk); #1;
    cfg_write(3'd7, 32'h1);
    @(negedge clk);
    check(verr_flag == 1'b0 && verr_index == '0, "R8 write-one clear", {verr_flag, verr_index}, 0);
    @(posedge clk); #1;

    check(exp_done.size() == 0, "R9 every block completed", exp_done.size(), 0);
    report();
  end

endmodule